// File: doc/BRIEF.md
# Tearing-Effect Line Trigger

This block decides when a frame transfer to a display panel may begin. The panel reports its scan position on a single tearing-effect line. Short pulses on that line mark each scan line, and a long pulse marks the start of a frame. The block measures the width of every pulse in clock cycles and sorts it into a horizontal mark, a vertical mark, or a glitch. It keeps a count of lines since the last vertical mark. When that count reaches a programmed line, it emits a single-cycle start pulse.

Software first selects a start source. A direct mode starts the transfer as soon as the enable is strobed. A line mode waits for the programmed line of the current frame. A frame mode waits for the next vertical mark. In both waiting modes the enable strobe arms the trigger once. After the start pulse fires, the trigger stays quiet until it is strobed again. Two threshold inputs give the minimum widths of a horizontal and a vertical mark. Two polarity inputs choose the active level of the line, one for each kind of mark. A setting that cannot separate the two kinds of pulse is flagged, and the trigger refuses to arm while the flag is set.

Top module: `te_sync_trigger`

## Requirements
- R1: With mode_i = 0 (direct), an enable strobe sampled on `arm_i` makes `start_o` high for the following cycle, whatever happens on `te_in`.
- R2: In modes 1 and 2, `cfg_bad_o` is high whenever `hs_width_i` < 2 or `hs_width_i` equals `vs_width_i`; in mode 0 it is always low.
- R3: `cfg_bad_o` is high in mode 1 when `vs_width_i` < 4, in mode 2 when `vs_width_i` < 2, and always in mode 3 (reserved).
- R4: While `cfg_bad_o` is high, an enable strobe does not arm the trigger, so no start pulse follows in modes 1 to 3, even after the setting is later corrected.
- R5: A pulse is the run of cycles in which the synchronised line is at its active level. A pulse of at least `vs_width_i` cycles is a vertical mark. A pulse of at least `hs_width_i` but fewer than `vs_width_i` cycles is a horizontal mark. A shorter pulse is ignored.
- R6: A vertical mark sets the line count to 0, and each horizontal mark adds 1, saturating at 2047. Horizontal marks before the first vertical mark after reset are ignored.
- R7: In mode 1 (line) an armed trigger fires at the vertical mark when `target_line_i` is 0. Otherwise it fires at the horizontal mark that brings the line count to `target_line_i`, including a mark that leaves a saturated count at 2047.
- R8: In mode 2 (frame) an armed trigger fires at the next vertical mark, and horizontal marks have no effect on it.
- R9: An armed trigger fires at most once. Further marks give no start pulse until the next enable strobe.
- R10: With `vs_act_low_i` = 1 or `hs_act_low_i` = 1, the matching detector treats a low level of `te_in` as active; with 0, it treats a high level as active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| te_in | input | 1 | Tearing-effect line from the panel, asynchronous |
| arm_i | input | 1 | Enable strobe, one cycle |
| mode_i | input | 2 | Start source: 0 direct, 1 line, 2 frame, 3 reserved |
| hs_act_low_i | input | 1 | Horizontal detection active low when 1 |
| vs_act_low_i | input | 1 | Vertical detection active low when 1 |
| hs_width_i | input | CNT_W | Minimum horizontal mark width in cycles |
| vs_width_i | input | CNT_W | Minimum vertical mark width in cycles |
| target_line_i | input | LINE_W | Line number that triggers in mode 1 |
| start_o | output | 1 | Single-cycle transfer start |
| cfg_bad_o | output | 1 | Threshold or mode setting rejected |

## Verification
The embedded assertions check on every cycle that a direct-mode strobe produces a start on the next cycle, and that a pulse end is reported only after an active cycle. They also check that a vertical mark clears the line count, that each accepted horizontal mark advances it by exactly one, and that a waiting-mode start never comes from a rejected setting and always leaves the trigger disarmed. Only the bench scenarios can show the threshold boundaries at exactly one cycle below and at each threshold. The same holds for the line at which the start arrives for each target, silence across a later frame, saturation at line 2047, and the effect of the polarity inputs. The bench also sweeps every mode against a grid of threshold pairs to check the rejection rules.

// File: rtl/te_trig_pkg.sv
package te_trig_pkg;
  typedef enum logic [1:0] {
    TRIG_DIRECT = 2'd0,
    TRIG_LINE   = 2'd1,
    TRIG_FRAME  = 2'd2,
    TRIG_RSVD   = 2'd3
  } trig_mode_e;

  localparam int unsigned HS_MIN       = 2;
  localparam int unsigned VS_MIN_LINE  = 4;
  localparam int unsigned VS_MIN_FRAME = 2;
endpackage

// File: rtl/te_in_sync.sv
module te_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d_i;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  output logic             end_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (act_i) cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign end_o = !act_i && (cnt_q != '0);
  assign len_o = cnt_q;

  // R5: a pulse end is only reported right after an active cycle
  p_end_after_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> $past(act_i));
endmodule

// File: rtl/te_cfg_check.sv
module te_cfg_check
  import te_trig_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] hs_width_i,
  input  logic [CNT_W-1:0] vs_width_i,
  output logic             bad_o
);
  trig_mode_e mode;
  logic hs_short, same_w, vs_short;

  always_comb begin
    mode     = trig_mode_e'(mode_i);
    hs_short = (hs_width_i < CNT_W'(HS_MIN));
    same_w   = (hs_width_i == vs_width_i);
    vs_short = 1'b0;
    bad_o    = 1'b0;
    case (mode)
      TRIG_DIRECT: bad_o = 1'b0;
      TRIG_LINE: begin
        vs_short = (vs_width_i < CNT_W'(VS_MIN_LINE));
        bad_o    = hs_short || same_w || vs_short;
      end
      TRIG_FRAME: begin
        vs_short = (vs_width_i < CNT_W'(VS_MIN_FRAME));
        bad_o    = hs_short || same_w || vs_short;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
  import te_trig_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              cfg_bad_i,
  input  logic              arm_i,
  input  logic              vs_hit_i,
  input  logic              hs_hit_i,
  input  logic [LINE_W-1:0] target_i,
  output logic              start_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  trig_mode_e mode;
  logic [LINE_W-1:0] line_q, line_d;
  logic seen_q, seen_d;
  logic armed_q, armed_d;
  logic start_q, fire;
  logic te_ok;

  always_comb begin
    mode   = trig_mode_e'(mode_i);
    line_d = line_q;
    seen_d = seen_q;
    if (vs_hit_i) begin
      line_d = '0;
      seen_d = 1'b1;
    end else if (hs_hit_i && seen_q && (line_q != LINE_MAX)) begin
      line_d = line_q + 1'b1;
    end

    te_ok = (mode != TRIG_DIRECT) && !cfg_bad_i && armed_q;
    case (mode)
      TRIG_DIRECT: fire = arm_i;
      TRIG_LINE:   fire = te_ok &&
                          ((vs_hit_i && (target_i == '0)) ||
                           (!vs_hit_i && hs_hit_i && seen_q && (line_d == target_i)));
      TRIG_FRAME:  fire = te_ok && vs_hit_i;
      default:     fire = 1'b0;
    endcase

    if (arm_i && (mode != TRIG_DIRECT) && !cfg_bad_i) armed_d = 1'b1;
    else if (fire || (mode == TRIG_DIRECT) || cfg_bad_i) armed_d = 1'b0;
    else armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      line_q  <= line_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
      start_q <= fire;
    end
  end

  assign start_o = start_q;

  // R1: direct-mode strobe starts on the next cycle
  p_direct_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_DIRECT && arm_i) |=> start_o);

  // R4: a waiting-mode start never comes from a rejected setting
  p_bad_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(mode != TRIG_DIRECT)) |-> $past(!cfg_bad_i));

  // R6: vertical mark clears the line count
  p_vs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_hit_i |=> (line_q == '0));

  // R6: accepted horizontal mark advances by one
  p_hs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_hit_i && !vs_hit_i && seen_q && (line_q != LINE_MAX)) |=>
      (line_q == $past(line_q) + 1'b1));

  // R9: a waiting-mode start leaves the trigger disarmed unless re-strobed
  p_single_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && $past(mode != TRIG_DIRECT)) |-> (!armed_q || $past(arm_i)));
endmodule

// File: rtl/te_sync_trigger.sv
module te_sync_trigger
  import te_trig_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LINE_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              te_in,
  input  logic              arm_i,
  input  logic [1:0]        mode_i,
  input  logic              hs_act_low_i,
  input  logic              vs_act_low_i,
  input  logic [CNT_W-1:0]  hs_width_i,
  input  logic [CNT_W-1:0]  vs_width_i,
  input  logic [LINE_W-1:0] target_line_i,
  output logic              start_o,
  output logic              cfg_bad_o
);
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  logic te_s;
  te_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(te_in), .q_o(te_s)
  );

  logic [1:0]       act;
  logic [1:0]       p_end;
  logic [CNT_W-1:0] p_len [2];
  logic [1:0]       act_low;

  assign act_low = {vs_act_low_i, hs_act_low_i};

  generate
    for (genvar k = 0; k < 2; k++) begin : g_meter
      assign act[k] = te_s ^ act_low[k];
      te_pulse_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_int_n), .act_i(act[k]),
        .end_o(p_end[k]), .len_o(p_len[k])
      );
    end
  endgenerate

  logic hs_hit, vs_hit;
  assign vs_hit = p_end[1] && (p_len[1] >= vs_width_i);
  assign hs_hit = p_end[0] && (p_len[0] >= hs_width_i) && (p_len[0] < vs_width_i);

  te_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .mode_i(mode_i), .hs_width_i(hs_width_i), .vs_width_i(vs_width_i),
    .bad_o(cfg_bad_o)
  );

  te_line_tracker #(.LINE_W(LINE_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode_i), .cfg_bad_i(cfg_bad_o),
    .arm_i(arm_i), .vs_hit_i(vs_hit), .hs_hit_i(hs_hit),
    .target_i(target_line_i), .start_o(start_o)
  );
endmodule

// File: tb/tb_te_sync_trigger.sv
`timescale 1ns/1ps
module tb_te_sync_trigger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        te_in, arm_i, hs_low, vs_low;
  logic [1:0]  mode;
  logic [7:0]  hs_w, vs_w;
  logic [10:0] target;
  logic        start_o, cfg_bad_o;

  int n_tests = 0;
  int n_fail  = 0;
  int starts  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  te_sync_trigger dut (
    .clk(clk), .rst_n(rst_n), .te_in(te_in), .arm_i(arm_i), .mode_i(mode),
    .hs_act_low_i(hs_low), .vs_act_low_i(vs_low), .hs_width_i(hs_w),
    .vs_width_i(vs_w), .target_line_i(target), .start_o(start_o),
    .cfg_bad_o(cfg_bad_o)
  );

  always @(negedge clk) if (rst_n && start_o) starts++;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    @(negedge clk) te_in = ~(vs_low);
    repeat (n) @(negedge clk);
    te_in = vs_low;
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; te_in = 1'b0; arm_i = 1'b0; hs_low = 1'b0; vs_low = 1'b0;
    mode = 2'd1; hs_w = 8'd3; vs_w = 8'd8; target = 11'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset start_o", int'(start_o), 0);
    chk("reset cfg_bad_o R2", int'(cfg_bad_o), 0);

    // R6: horizontal mark before any vertical mark ignored
    strobe();
    pulse(4);
    chk("R6 hsync before first vsync", starts, 0);
    pulse(10);
    chk("R7 no start at vsync for target 1", starts, 0);
    pulse(4);
    chk("R7 start at line 1", starts, 1);

    // R7 sweep over targets
    for (int t = 0; t < 6; t++) begin
      target = 11'(t);
      base = starts;
      strobe();
      pulse(10);
      chk($sformatf("R7 t=%0d after vsync", t), starts - base, (t == 0) ? 1 : 0);
      for (int l = 1; l <= 7; l++) begin
        pulse(4);
        chk($sformatf("R7 t=%0d after line %0d", t, l), starts - base, (l >= t) ? 1 : 0);
      end
    end

    // R9: next frame without strobe is quiet
    base = starts;
    pulse(10);
    for (int l = 0; l < 7; l++) pulse(4);
    chk("R9 no second start without strobe", starts - base, 0);

    // R5: glitch and threshold edges
    target = 11'd2; base = starts;
    strobe(); pulse(10); pulse(4); pulse(2);
    chk("R5 glitch below hs width ignored", starts - base, 0);
    pulse(3);
    chk("R5 pulse at hs width counts", starts - base, 1);
    target = 11'd1; base = starts;
    strobe(); pulse(10); pulse(7);
    chk("R5 pulse one below vs width is hsync", starts - base, 1);
    target = 11'd0; base = starts;
    strobe(); pulse(8);
    chk("R5 pulse at vs width is vsync", starts - base, 1);

    // R8: frame mode
    mode = 2'd2; target = 11'd3; base = starts;
    strobe(); pulse(4); pulse(4); pulse(4);
    chk("R8 hsyncs give no start in frame mode", starts - base, 0);
    pulse(10);
    chk("R8 start at vsync", starts - base, 1);
    pulse(10);
    chk("R9 frame mode fires once", starts - base, 1);

    // R1: direct mode
    mode = 2'd0; base = starts;
    @(negedge clk) arm_i = 1'b1;
    @(negedge clk) arm_i = 1'b0;
    chk("R1 start one cycle after strobe", int'(start_o) + (starts - base), 1);
    @(negedge clk);
    chk("R1 start lasts one cycle", starts - base, 1);

    // R2, R3: rejection sweep
    for (int m = 0; m < 4; m++)
      for (int h = 0; h < 7; h++)
        for (int v = 0; v < 7; v++) begin
          int e;
          @(negedge clk);
          mode = 2'(m); hs_w = 8'(h); vs_w = 8'(v);
          #1;
          if (m == 0) e = 0;
          else if (m == 3) e = 1;
          else e = ((h < 2) || (h == v) || (v < ((m == 1) ? 4 : 2))) ? 1 : 0;
          chk($sformatf("R2 R3 cfg m=%0d hs=%0d vs=%0d", m, h, v), int'(cfg_bad_o), e);
        end

    // R4: rejected setting ignores strobe
    @(negedge clk) mode = 2'd1; hs_w = 8'd5; vs_w = 8'd5; target = 11'd0;
    base = starts;
    strobe(); pulse(10);
    chk("R4 no start with rejected setting", starts - base, 0);
    @(negedge clk) hs_w = 8'd3; vs_w = 8'd8;
    pulse(10); pulse(4);
    chk("R4 strobe under rejected setting did not arm", starts - base, 0);

    // R10: active-low polarity
    @(negedge clk) te_in = 1'b1; hs_low = 1'b1; vs_low = 1'b1;
    repeat (8) @(negedge clk);
    target = 11'd1; base = starts;
    strobe(); pulse(10);
    chk("R10 active-low vsync no early start", starts - base, 0);
    pulse(4);
    chk("R10 active-low line 1 start", starts - base, 1);
    @(negedge clk) te_in = 1'b0; hs_low = 1'b0; vs_low = 1'b0;
    repeat (8) @(negedge clk);

    // R6, R7: line 2047 and saturation
    target = 11'd2047; base = starts;
    strobe(); pulse(10);
    for (int l = 1; l < 2047; l++) pulse(3);
    chk("R7 no start before line 2047", starts - base, 0);
    pulse(3);
    chk("R7 start at line 2047", starts - base, 1);
    strobe(); pulse(3);
    chk("R6 count saturates at 2047", starts - base, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule